// File: doc/BRIEF.md
# Programmable clock phase and duty-cycle generator

This block is a synthesizable model of a 32-step clock manager working as a tapped delay line. A fast sampling clock `clk` runs at 32 times the rate of a slow reference clock `ref_clk_in`. The reference must be synchronous to `clk`, or synchronised before it reaches the block. The reference first passes through a pre-divider with an integer ratio from 1 to 8. The divided clock then feeds two generators. One produces a copy of the divided clock delayed by N fast cycles. The other produces a pulse that rises with the divided clock and stays high for N fast cycles. With an undivided reference, one fast cycle is 1/32 of the reference period, or 3.125 %.

The step count N (1 to 31) comes from an 8-bit step code that has two ranges. A mode input enables one generator and holds the other at 0. Two independent 2-bit selectors route a generator to the two outputs: an I/O clock and a system clock. The I/O output can also pass the delayed clock through a post-divider with a ratio from 1 to 8. Both divider ratios are taken only at a rising edge of the clock they divide, so a change never creates a runt pulse.

Top module: `pcm_dll_top`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first divided-clock edge, both outputs are 0.
- R2: A step code with bit 7 = 0 and bits 6:3 not all ones decodes to N = {bit 6, bits 2:0} + 1, which gives 1 to 16. Bits 5:3 are ignored in this range.
- R3: A step code with bit 7 = 1, or with bits 6:3 = 1111, decodes to N = bits 7:3 + 1. Bits 2:0 are ignored. Code 11111xxx saturates to N = 31.
- R4: Duty path (`duty_mode` = 1, selector 01). This timing assumes a reference of 32 fast cycles, 16 high. The output rises 3 cycles after the sampled reference edge that starts a divided period, stays high for N cycles, and repeats every 32·D cycles.
- R5: Delayed path (`duty_mode` = 0, selector 10). The output rises 3 + N cycles after that same reference edge, stays high for 16·D cycles, and repeats every 32·D cycles.
- R6: `pre_div` = k gives D = k + 1. The divided clock toggles after every D sampled reference edges, so its duty is 50 % for any D.
- R7: A new `pre_div` value takes effect at the next rising edge of the divided clock. The high and low phases already under way keep the old ratio.
- R8: I/O selector 11 passes the delayed clock through a post-divider with ratio P = `io_div` + 1. The output rises 4 + N cycles after the reference edge, stays high for 16·D·P cycles, and repeats every 32·D·P cycles.
- R9: System selector 11 gives the delayed clock undivided, with the same timing as selector 10.
- R10: Selector code 00 holds the corresponding output at 0.
- R11: With `duty_mode` = 0 the duty path stays at 0. With `duty_mode` = 1 the delayed path is 0 once the mode has been held for more than 32 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock, 32 times the reference rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ref_clk_in | input | 1 | Slow reference clock, synchronous to `clk` |
| pre_div | input | 3 | Pre-divider ratio minus one |
| step_code | input | 8 | Two-range step code giving N |
| duty_mode | input | 1 | 0 enables the delayed path, 1 enables the duty path |
| io_sel | input | 2 | I/O output source: 00 off, 01 duty, 10 delayed, 11 delayed and post-divided |
| sys_sel | input | 2 | System output source: 00 off, 01 duty, 10 and 11 delayed |
| io_div | input | 3 | Post-divider ratio minus one |
| io_clk_out | output | 1 | I/O clock output, registered |
| sys_clk_out | output | 1 | System clock output, registered |

## Verification
The assertions check on every cycle that a 00 selector keeps its output low. They also check that the disabled generator cannot reach an output once the mode has settled, and that a duty pulse never lasts a full reference period. The exact edge positions can only be shown by the bench's scenarios. These cover the two decoder ranges and their ignored bits, the delay offset against the duty rise, the high and period lengths for each pre- and post-divider ratio, and the deferred ratio change. The bench measures each of these against the reference edge.

// File: rtl/pcm_pkg.sv
`timescale 1ns/1ps
package pcm_pkg;
  localparam int unsigned TAPS  = 32;
  localparam int unsigned TAP_W = $clog2(TAPS);
  localparam int unsigned DIV_W = 3;

  typedef enum logic [1:0] {
    SRC_OFF       = 2'b00,
    SRC_DUTY      = 2'b01,
    SRC_DELAY     = 2'b10,
    SRC_DELAY_DIV = 2'b11
  } src_sel_e;

  // Two-range step decode: upper range when bit 7 set or bits 6:3 all ones.
  function automatic logic [TAP_W-1:0] decode_step(input logic [7:0] code);
    logic       upper;
    logic [5:0] val;
    upper = code[7] | (code[6:3] == 4'b1111);
    if (upper) val = {1'b0, code[7:3]} + 6'd1;
    else       val = {2'b00, code[6], code[2:0]} + 6'd1;
    if (val > 6'(TAPS - 1)) val = 6'(TAPS - 1);
    return val[TAP_W-1:0];
  endfunction
endpackage

// File: rtl/pcm_edge_divider.sv
`timescale 1ns/1ps
module pcm_edge_divider #(
  parameter int unsigned DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sig_in,
  input  logic [DIV_W-1:0] ratio_in,
  output logic             clk_out
);
  logic             sig_q;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] ratio_q, ratio_d;
  logic             out_q, out_d;
  logic             edge_seen;

  assign edge_seen = sig_in ^ sig_q;

  always_comb begin
    cnt_d   = cnt_q;
    ratio_d = ratio_q;
    out_d   = out_q;
    if (edge_seen) begin
      if (cnt_q == ratio_q) begin
        cnt_d = '0;
        out_d = ~out_q;
        if (!out_q) ratio_d = ratio_in;  // new ratio only at a rising toggle
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_q   <= 1'b0;
      cnt_q   <= '0;
      ratio_q <= '0;
      out_q   <= 1'b0;
    end else begin
      sig_q   <= sig_in;
      cnt_q   <= cnt_d;
      ratio_q <= ratio_d;
      out_q   <= out_d;
    end
  end

  assign clk_out = out_q;
endmodule

// File: rtl/pcm_tap_delay.sv
`timescale 1ns/1ps
module pcm_tap_delay #(
  parameter int unsigned TAPS  = 32,
  localparam int unsigned TAP_W = $clog2(TAPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic [TAP_W-1:0] tap,
  output logic             dout
);
  logic [TAPS-1:0] line_q, line_d;

  generate
    for (genvar i = 0; i < TAPS; i++) begin : g_stage
      if (i == 0) begin : g_head
        assign line_d[i] = din;
      end else begin : g_body
        assign line_d[i] = line_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '0;
    else        line_q <= line_d;
  end

  assign dout = line_q[tap];
endmodule

// File: rtl/pcm_duty_shaper.sv
`timescale 1ns/1ps
module pcm_duty_shaper #(
  parameter int unsigned TAP_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             src,
  input  logic [TAP_W-1:0] width,
  output logic             pulse_out
);
  logic             src_q;
  logic             hi_q, hi_d;
  logic [TAP_W-1:0] cnt_q, cnt_d;
  logic             src_rise;

  assign src_rise = src & ~src_q;

  always_comb begin
    hi_d  = hi_q;
    cnt_d = cnt_q;
    if (!enable) begin
      hi_d  = 1'b0;
      cnt_d = '0;
    end else if (src_rise) begin
      hi_d  = 1'b1;
      cnt_d = TAP_W'(1);
    end else if (hi_q) begin
      if (cnt_q >= width) hi_d = 1'b0;
      else                cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= 1'b0;
      hi_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      src_q <= src;
      hi_q  <= hi_d;
      cnt_q <= cnt_d;
    end
  end

  assign pulse_out = hi_q;
endmodule

// File: rtl/pcm_dll_top.sv
`timescale 1ns/1ps
module pcm_dll_top
  import pcm_pkg::*;
#(
  parameter int unsigned DIV_W = pcm_pkg::DIV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_clk_in,
  input  logic [DIV_W-1:0] pre_div,
  input  logic [7:0]       step_code,
  input  logic             duty_mode,
  input  logic [1:0]       io_sel,
  input  logic [1:0]       sys_sel,
  input  logic [DIV_W-1:0] io_div,
  output logic             io_clk_out,
  output logic             sys_clk_out
);
  logic [1:0]       rst_pipe;
  logic             core_rst_n;
  logic [TAP_W-1:0] step;
  logic             div_clk, dly_in, dly_clk, dly_div_clk, duty_clk;
  logic             io_d, sys_d, io_q, sys_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign core_rst_n = rst_pipe[1];

  assign step   = decode_step(step_code);
  assign dly_in = div_clk & ~duty_mode;

  pcm_edge_divider #(.DIV_W(DIV_W)) u_pre_div (
    .clk(clk), .rst_n(core_rst_n), .sig_in(ref_clk_in),
    .ratio_in(pre_div), .clk_out(div_clk)
  );

  pcm_tap_delay #(.TAPS(TAPS)) u_delay (
    .clk(clk), .rst_n(core_rst_n), .din(dly_in),
    .tap(step), .dout(dly_clk)
  );

  pcm_duty_shaper #(.TAP_W(TAP_W)) u_duty (
    .clk(clk), .rst_n(core_rst_n), .enable(duty_mode),
    .src(div_clk), .width(step), .pulse_out(duty_clk)
  );

  pcm_edge_divider #(.DIV_W(DIV_W)) u_post_div (
    .clk(clk), .rst_n(core_rst_n), .sig_in(dly_clk),
    .ratio_in(io_div), .clk_out(dly_div_clk)
  );

  always_comb begin
    unique case (src_sel_e'(io_sel))
      SRC_OFF:       io_d = 1'b0;
      SRC_DUTY:      io_d = duty_clk;
      SRC_DELAY:     io_d = dly_clk;
      SRC_DELAY_DIV: io_d = dly_div_clk;
      default:       io_d = 1'b0;
    endcase
    unique case (src_sel_e'(sys_sel))
      SRC_OFF:       sys_d = 1'b0;
      SRC_DUTY:      sys_d = duty_clk;
      SRC_DELAY:     sys_d = dly_clk;
      SRC_DELAY_DIV: sys_d = dly_clk;  // system output is never post-divided
      default:       sys_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      io_q  <= 1'b0;
      sys_q <= 1'b0;
    end else begin
      io_q  <= io_d;
      sys_q <= sys_d;
    end
  end

  assign io_clk_out  = io_q;
  assign sys_clk_out = sys_q;
endmodule

// File: rtl/pcm_dll_checker.sv
`timescale 1ns/1ps
module pcm_dll_checker #(
  parameter int unsigned TAPS = 32
) (
  input logic       clk,
  input logic       rst_n,
  input logic       duty_mode,
  input logic [1:0] io_sel,
  input logic [1:0] sys_sel,
  input logic       io_clk_out,
  input logic       sys_clk_out
);
  logic [5:0] mode_run_q, sel_run_q, hi_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_run_q <= '0;
      sel_run_q  <= '0;
      hi_run_q   <= '0;
    end else begin
      mode_run_q <= !duty_mode ? 6'd0 : (mode_run_q == 6'd63 ? mode_run_q : mode_run_q + 6'd1);
      sel_run_q  <= !(duty_mode && sys_sel == 2'b01) ? 6'd0
                    : (sel_run_q == 6'd63 ? sel_run_q : sel_run_q + 6'd1);
      hi_run_q   <= !sys_clk_out ? 6'd0 : (hi_run_q == 6'd63 ? hi_run_q : hi_run_q + 6'd1);
    end
  end

  a_r10_sys_off: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sys_sel) == 2'b00) |-> !sys_clk_out);

  a_r10_io_off: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(io_sel) == 2'b00) |-> !io_clk_out);

  a_r11_duty_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(duty_mode, 2) && $past(sys_sel) == 2'b01) |-> !sys_clk_out);

  a_r11_delay_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_run_q >= 6'(TAPS + 1) && $past(sys_sel) == 2'b10) |-> !sys_clk_out);

  a_r4_duty_short: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_run_q >= 6'(TAPS + 4)) |-> (hi_run_q < 6'(TAPS)));
endmodule

bind pcm_dll_top pcm_dll_checker #(.TAPS(pcm_pkg::TAPS)) i_chk (
  .clk(clk), .rst_n(rst_n), .duty_mode(duty_mode), .io_sel(io_sel),
  .sys_sel(sys_sel), .io_clk_out(io_clk_out), .sys_clk_out(sys_clk_out)
);

// File: tb/test_pcm_dll_top.sv
`timescale 1ns/1ps
module test_pcm_dll_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_clk_in = 1'b0;
  logic [2:0] pre_div = '0;
  logic [7:0] step_code = '0;
  logic       duty_mode = 1'b0;
  logic [1:0] io_sel = '0;
  logic [1:0] sys_sel = '0;
  logic [2:0] io_div = '0;
  logic       io_clk_out, sys_clk_out;

  int cyc = 0;
  int first_rise = -1;
  int rcnt = 16;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int ev[5];

  pcm_dll_top i_pcm_dll_top (
    .clk(clk), .rst_n(rst_n), .ref_clk_in(ref_clk_in), .pre_div(pre_div),
    .step_code(step_code), .duty_mode(duty_mode), .io_sel(io_sel),
    .sys_sel(sys_sel), .io_div(io_div), .io_clk_out(io_clk_out),
    .sys_clk_out(sys_clk_out)
  );

  always #2 clk = ~clk;  // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  // reference: 32 fast cycles, 16 high, restarted low by each reset
  always @(negedge clk) begin
    if (!rst_n) begin
      rcnt = 16;
      first_rise = -1;
    end else begin
      rcnt = (rcnt + 1) % 32;
      if (rcnt == 0 && first_rise < 0) first_rise = cyc;
    end
    ref_clk_in = (rcnt < 16);
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): actual hung, expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] enc(input int n, input int dc);
    logic [4:0] m;
    logic [2:0] d;
    m = 5'(n - 1);
    d = 3'(dc % 7);
    if (n <= 15) return {1'b0, m[3], d, m[2:0]};
    return {m, 3'(dc)};
  endfunction

  task automatic start(input logic [2:0] pd, input logic [7:0] code, input logic mode,
                       input logic [1:0] isel, input logic [1:0] ssel, input logic [2:0] idv);
    @(negedge clk);
    rst_n = 1'b0;
    pre_div = pd; step_code = code; duty_mode = mode;
    io_sel = isel; sys_sel = ssel; io_div = idv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // record up to five output transitions relative to the first reference rise
  task automatic capture(input bit use_io, input int limit, input bit chg, input logic [2:0] nv);
    logic prev, cur;
    int   n;
    prev = 1'b0;
    n = 0;
    for (int i = 0; i < 5; i++) ev[i] = -1;
    for (int t = 0; t < limit && n < 5; t++) begin
      @(negedge clk);
      cur = use_io ? io_clk_out : sys_clk_out;
      if (cur != prev) begin
        ev[n] = cyc - first_rise;
        if (n == 0 && chg) pre_div = nv;
        n++;
      end
      prev = cur;
    end
  endtask

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    check("R1", "io during reset", int'(io_clk_out), 0);
    check("R1", "sys during reset", int'(sys_clk_out), 0);
    start(3'd0, enc(5, 1), 1'b1, 2'b01, 2'b01, 3'd0);
    repeat (6) @(negedge clk);
    check("R1", "io before first edge", int'(io_clk_out), 0);
    check("R1", "sys before first edge", int'(sys_clk_out), 0);

    // R2, R3, R4: duty pulse width over every code, ignored bits varied
    for (int n = 1; n <= 31; n++) begin
      start(3'd0, enc(n, n * 3 + 1), 1'b1, 2'b00, 2'b01, 3'd0);
      capture(1'b0, 200, 1'b0, 3'd0);
      check(n <= 15 ? "R2" : "R3", "duty rise", ev[0], 3);
      check(n <= 15 ? "R2" : "R3", "duty high", ev[1] - ev[0], n);
      check("R4", "duty period", ev[2] - ev[0], 32);
    end
    // R3: saturating top code
    start(3'd0, 8'b1111_1101, 1'b1, 2'b01, 2'b00, 3'd0);
    capture(1'b1, 200, 1'b0, 3'd0);
    check("R3", "saturated width", ev[1] - ev[0], 31);

    // R4, R6: duty pulse under every pre-divider ratio
    for (int d = 1; d <= 8; d++) begin
      start(3'(d - 1), enc(7, d), 1'b1, 2'b01, 2'b00, 3'd0);
      capture(1'b1, 64 * d + 100, 1'b0, 3'd0);
      check("R4", "duty high", ev[1] - ev[0], 7);
      check("R6", "duty period", ev[2] - ev[0], 32 * d);
    end

    // R5, R6: delayed clock over every code, ratio varied
    for (int n = 1; n <= 31; n++) begin
      int d;
      d = (n % 8) + 1;
      start(3'(d - 1), enc(n, n), 1'b0, 2'b10, 2'b00, 3'd0);
      capture(1'b1, 64 * d + 100, 1'b0, 3'd0);
      check("R5", "delayed rise", ev[0], 3 + n);
      check("R6", "delayed high", ev[1] - ev[0], 16 * d);
      check("R6", "delayed period", ev[2] - ev[0], 32 * d);
    end

    // R9: system selector 11 is the undivided delayed clock
    for (int d = 1; d <= 3; d++) begin
      start(3'(d - 1), enc(9, 2), 1'b0, 2'b00, 2'b11, 3'd5);
      capture(1'b0, 64 * d + 100, 1'b0, 3'd0);
      check("R9", "sys11 rise", ev[0], 12);
      check("R9", "sys11 high", ev[1] - ev[0], 16 * d);
      check("R9", "sys11 period", ev[2] - ev[0], 32 * d);
    end

    // R8: post-divided I/O clock
    for (int d = 1; d <= 2; d++) begin
      for (int p = 1; p <= 8; p++) begin
        int n;
        n = 2 * p + 1;
        start(3'(d - 1), enc(n, p), 1'b0, 2'b11, 2'b10, 3'(p - 1));
        capture(1'b1, 64 * d * p + 100, 1'b0, 3'd0);
        check("R8", "post rise", ev[0], 4 + n);
        check("R8", "post high", ev[1] - ev[0], 16 * d * p);
        check("R8", "post period", ev[2] - ev[0], 32 * d * p);
      end
    end

    // R7: ratio change applies from the next divided rising edge
    start(3'd0, enc(1, 0), 1'b0, 2'b00, 2'b10, 3'd0);
    capture(1'b0, 400, 1'b1, 3'd3);
    check("R7", "old high kept", ev[1] - ev[0], 16);
    check("R7", "old low kept", ev[2] - ev[1], 16);
    check("R7", "new high", ev[3] - ev[2], 64);
    check("R7", "new period", ev[4] - ev[2], 128);

    // R10: selector 00 keeps an output low while the other runs
    start(3'd0, enc(4, 0), 1'b0, 2'b10, 2'b00, 3'd0);
    capture(1'b0, 150, 1'b0, 3'd0);
    check("R10", "sys off transitions", ev[0], -1);
    check("R10", "io still active", int'(io_clk_out) | int'(ev[0] == -1), 1);
    start(3'd0, enc(4, 0), 1'b1, 2'b00, 2'b01, 3'd0);
    capture(1'b1, 150, 1'b0, 3'd0);
    check("R10", "io off transitions", ev[0], -1);

    // R11: the disabled generator never reaches an output
    start(3'd0, enc(20, 0), 1'b1, 2'b01, 2'b10, 3'd0);
    capture(1'b0, 150, 1'b0, 3'd0);
    check("R11", "delay path in duty mode", ev[0], -1);
    start(3'd0, enc(20, 0), 1'b0, 2'b01, 2'b10, 3'd0);
    capture(1'b1, 150, 1'b0, 3'd0);
    check("R11", "duty path in delay mode", ev[0], -1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule